// File: doc/BRIEF.md
# Power-On Strap Capture and Pin Role Select

This block samples the configuration straps found on pins that double as clock outputs. While the power-on window is open, the block copies the strap levels into its latch on every clock edge. These straps are three frequency-select bits, a desktop/mobile mode bit and a CPU buffer voltage bit. When the window closes, the latch holds its contents. After a short guard interval, the block enables the output drivers of the shared pins. The guard keeps a driven clock from disturbing the last level that was sampled.

From the stored straps the block produces the following:
- The 3-bit frequency code for a downstream lookup. The code comes from the straps, or from a register field when the register's override bit is set.
- A readback copy of the frequency straps.
- The role of two dual-purpose pins. In desktop mode they are clock outputs. In mobile mode they are active-low stop-request inputs, and the block forwards their levels.

Top module: `strap_ctrl`

## Requirements
- R1: While rst_ni is low, pin_oe_o and dual_oe_o are all zero, stop_n_o is 2'b11, and the latched straps take their reset value, which is all ones (fs_lat_o=3'b111, mode_lat_o=1, vsel_lat_o=1).
- R2: At each rising clock edge where por_i is high, the pin levels are loaded into fs_lat_o, mode_lat_o and vsel_lat_o. The loaded values are visible after that edge.
- R3: At edges where por_i is low, the latched straps keep their value whatever the strap pins do. They change only at an edge with por_i high.
- R4: pin_oe_o (all bits equal) is low whenever por_i is high. It goes high only after HOLD_CYCLES (default 2) consecutive rising edges have occurred with por_i low. It returns low as soon as por_i is asserted again.
- R5: When reg_override_i=0, freq_code_o equals fs_lat_o. When reg_override_i=1, freq_code_o equals reg_code_i. Bit 2 is the most significant bit in both cases.
- R6: fs_rdbk_o is the bitwise inverse of fs_lat_o.
- R7: vsel_lat_o holds the captured voltage strap, where 1 selects 2.5 V CPU buffers and 0 selects 3.3 V.
- R8: With mode_lat_o=1 (desktop), dual_oe_o is 2'b11 once pin_oe_o is high. stop_n_o stays at 2'b11 regardless of dual_pin_i.
- R9: With mode_lat_o=0 (mobile), dual_oe_o is 2'b00. Once pin_oe_o is high, stop_n_o follows dual_pin_i, where bit 0 is the CPU stop request and bit 1 is the PCI stop request. Before that, stop_n_o is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_i | input | 1 | Power-on window; the latch is open while high |
| strap_fs_i | input | 3 | Frequency-select strap levels |
| strap_mode_i | input | 1 | Mode strap level (1 desktop, 0 mobile) |
| strap_vsel_i | input | 1 | CPU buffer voltage strap level |
| dual_pin_i | input | 2 | Input levels of the dual-role pins |
| reg_override_i | input | 1 | Selects the register code over the straps |
| reg_code_i | input | 3 | Register frequency code |
| fs_lat_o | output | 3 | Latched frequency straps |
| fs_rdbk_o | output | 3 | Inverted latched frequency straps for readback |
| mode_lat_o | output | 1 | Latched mode strap |
| vsel_lat_o | output | 1 | Latched voltage strap |
| pin_oe_o | output | NUM_SHARED | Output enables of the shared strap pins |
| dual_oe_o | output | 2 | Output enables of the dual-role pins |
| stop_n_o | output | 2 | Active-low stop requests |
| freq_code_o | output | 3 | Selected frequency code |

## Verification
The following are checked on every cycle:
- The latch is frozen while the window is closed, and it loads at each open edge.
- The enables only rise after the window has closed, and they follow the latched mode.
- In desktop mode the stop requests stay idle.

Some behaviour can only be shown by the bench's scenarios. These cover the exact guard interval before the enables rise, and the override selection across all eight codes. They also cover the forwarding of stop pins in mobile mode, and a second power-on window that reloads different straps.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned FS_W = 3;
  localparam int unsigned DUAL_W = 2;
  localparam int unsigned STRAP_W = FS_W + 2;

  typedef struct packed {
    logic [FS_W-1:0] fs;
    logic            mode;
    logic            vsel;
  } strap_t;
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
#(
  parameter logic [STRAP_W-1:0] RST_VAL = '1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   open_i,
  input  strap_t pins_i,
  output strap_t lat_o
);
  strap_t lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lat_q <= strap_t'(RST_VAL);
    else if (open_i) lat_q <= pins_i;
  end

  assign lat_o = lat_q;
endmodule

// File: rtl/strap_release.sv
module strap_release #(
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_i,
  output logic released_o
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (por_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  // drop at once when a new power-on window opens
  assign released_o = done_q & ~por_i;
endmodule

// File: rtl/strap_route.sv
module strap_route
  import strap_pkg::*;
#(
  parameter int unsigned NUM_SHARED = 5
) (
  input  strap_t            lat_i,
  input  logic              released_i,
  input  logic              override_i,
  input  logic [FS_W-1:0]   reg_code_i,
  input  logic [DUAL_W-1:0] dual_pin_i,
  output logic [NUM_SHARED-1:0] pin_oe_o,
  output logic [DUAL_W-1:0] dual_oe_o,
  output logic [DUAL_W-1:0] stop_n_o,
  output logic [FS_W-1:0]   freq_code_o,
  output logic [FS_W-1:0]   fs_rdbk_o
);
  for (genvar g = 0; g < NUM_SHARED; g++) begin : g_oe
    assign pin_oe_o[g] = released_i;
  end

  for (genvar d = 0; d < DUAL_W; d++) begin : g_dual
    assign dual_oe_o[d] = released_i &  lat_i.mode;
    assign stop_n_o[d]  = (released_i & ~lat_i.mode) ? dual_pin_i[d] : 1'b1;
  end

  assign freq_code_o = override_i ? reg_code_i : lat_i.fs;
  assign fs_rdbk_o   = ~lat_i.fs;
endmodule

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int unsigned NUM_SHARED  = 5,
  parameter int unsigned HOLD_CYCLES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  por_i,
  input  logic [2:0]            strap_fs_i,
  input  logic                  strap_mode_i,
  input  logic                  strap_vsel_i,
  input  logic [1:0]            dual_pin_i,
  input  logic                  reg_override_i,
  input  logic [2:0]            reg_code_i,
  output logic [2:0]            fs_lat_o,
  output logic [2:0]            fs_rdbk_o,
  output logic                  mode_lat_o,
  output logic                  vsel_lat_o,
  output logic [NUM_SHARED-1:0] pin_oe_o,
  output logic [1:0]            dual_oe_o,
  output logic [1:0]            stop_n_o,
  output logic [2:0]            freq_code_o
);
  strap_t pins, lat;
  logic   released;

  assign pins = '{fs: strap_fs_i, mode: strap_mode_i, vsel: strap_vsel_i};

  strap_capture #(.RST_VAL('1)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_i (por_i),
    .pins_i (pins),
    .lat_o  (lat)
  );

  strap_release #(.HOLD_CYCLES(HOLD_CYCLES)) u_rel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_i      (por_i),
    .released_o (released)
  );

  strap_route #(.NUM_SHARED(NUM_SHARED)) u_route (
    .lat_i       (lat),
    .released_i  (released),
    .override_i  (reg_override_i),
    .reg_code_i  (reg_code_i),
    .dual_pin_i  (dual_pin_i),
    .pin_oe_o    (pin_oe_o),
    .dual_oe_o   (dual_oe_o),
    .stop_n_o    (stop_n_o),
    .freq_code_o (freq_code_o),
    .fs_rdbk_o   (fs_rdbk_o)
  );

  assign fs_lat_o   = lat.fs;
  assign mode_lat_o = lat.mode;
  assign vsel_lat_o = lat.vsel;
endmodule

// File: rtl/strap_ctrl_chk.sv
module strap_ctrl_chk #(
  parameter int unsigned NUM_SHARED = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  por_i,
  input logic [2:0]            strap_fs_i,
  input logic                  strap_mode_i,
  input logic                  strap_vsel_i,
  input logic [2:0]            fs_lat_o,
  input logic                  mode_lat_o,
  input logic                  vsel_lat_o,
  input logic [NUM_SHARED-1:0] pin_oe_o,
  input logic [1:0]            dual_oe_o,
  input logic [1:0]            stop_n_o
);
  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(por_i)) |->
      (fs_lat_o == $past(strap_fs_i) && mode_lat_o == $past(strap_mode_i)
       && vsel_lat_o == $past(strap_vsel_i)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(por_i) |-> ($stable(fs_lat_o) && $stable(mode_lat_o) && $stable(vsel_lat_o)));

  p_oe_after_close_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pin_oe_o[0]) |-> (!$past(por_i) && !por_i));

  p_oe_off_in_por_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |-> (pin_oe_o == '0 && dual_oe_o == '0));

  p_desktop_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_lat_o |-> (stop_n_o == 2'b11));

  p_mobile_no_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_lat_o |-> (dual_oe_o == 2'b00));
endmodule

bind strap_ctrl strap_ctrl_chk #(.NUM_SHARED(NUM_SHARED)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .por_i        (por_i),
  .strap_fs_i   (strap_fs_i),
  .strap_mode_i (strap_mode_i),
  .strap_vsel_i (strap_vsel_i),
  .fs_lat_o     (fs_lat_o),
  .mode_lat_o   (mode_lat_o),
  .vsel_lat_o   (vsel_lat_o),
  .pin_oe_o     (pin_oe_o),
  .dual_oe_o    (dual_oe_o),
  .stop_n_o     (stop_n_o)
);

// File: tb/strap_ctrl_test.sv
module strap_ctrl_test;
  localparam int NSH = 5;
  localparam int HOLD = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b1;
  logic           por = 1'b1;
  logic [2:0]     fs_pin = 3'b010;
  logic           mode_pin = 1'b1;
  logic           vsel_pin = 1'b0;
  logic [1:0]     dual_pin = 2'b00;
  logic           ovr = 1'b0;
  logic [2:0]     rcode = 3'b000;
  logic [2:0]     fs_lat, fs_rdbk, fcode;
  logic           mode_lat, vsel_lat;
  logic [NSH-1:0] pin_oe;
  logic [1:0]     dual_oe, stop_n;

  int total = 0;
  int bad = 0;
  bit chk_en = 1'b0;

  always #5 clk = ~clk;

  strap_ctrl #(.NUM_SHARED(NSH), .HOLD_CYCLES(HOLD)) uut (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por),
    .strap_fs_i(fs_pin), .strap_mode_i(mode_pin), .strap_vsel_i(vsel_pin),
    .dual_pin_i(dual_pin), .reg_override_i(ovr), .reg_code_i(rcode),
    .fs_lat_o(fs_lat), .fs_rdbk_o(fs_rdbk), .mode_lat_o(mode_lat),
    .vsel_lat_o(vsel_lat), .pin_oe_o(pin_oe), .dual_oe_o(dual_oe),
    .stop_n_o(stop_n), .freq_code_o(fcode)
  );

  // behavioural reference
  int m_fs = 7, m_mode = 1, m_vsel = 1, m_cnt = 0;
  bit m_done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fs = 7; m_mode = 1; m_vsel = 1; m_cnt = 0; m_done = 0;
    end else if (por) begin
      m_fs = fs_pin; m_mode = mode_pin; m_vsel = vsel_pin; m_cnt = 0; m_done = 0;
    end else if (!m_done) begin
      m_cnt++;
      if (m_cnt >= HOLD) m_done = 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      bit rel;
      rel = m_done && !por;
      chk(por ? "R2 latch load" : "R3 latch hold", {fs_lat, mode_lat, vsel_lat},
          (m_fs << 2) | (m_mode << 1) | m_vsel);
      chk("R4 pin enable", pin_oe, rel ? (1 << NSH) - 1 : 0);
      chk("R5 freq code", fcode, ovr ? rcode : m_fs);
      chk("R6 readback", fs_rdbk, (~m_fs) & 7);
      chk("R7 voltage strap", vsel_lat, m_vsel);
      if (m_mode != 0) begin
        chk("R8 desktop enable", dual_oe, rel ? 3 : 0);
        chk("R8 desktop stop idle", stop_n, 3);
      end else begin
        chk("R9 mobile enable", dual_oe, 0);
        chk("R9 mobile stop", stop_n, rel ? dual_pin : 3);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #1 chk_en = 1'b1;
    step(2);
    // R1 reset values at the ports
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 dual_oe", dual_oe, 0);
    chk("R1 stop_n", stop_n, 3);
    chk("R1 straps", {fs_lat, mode_lat, vsel_lat}, 5'b11111);
    rst_n = 1'b1;
    // R2: latch follows pins during window (desktop strap)
    for (int i = 0; i < 4; i++) begin
      fs_pin = 3'(i * 3 + 1); vsel_pin = i[0];
      step(1);
    end
    fs_pin = 3'b101; vsel_pin = 1'b1; mode_pin = 1'b1;
    step(1);
    por = 1'b0;
    // R3/R4/R8: pins wiggle after close, guard interval, desktop roles
    for (int i = 0; i < 6; i++) begin
      fs_pin = 3'(i); mode_pin = i[0]; vsel_pin = ~i[1]; dual_pin = 2'(i);
      step(1);
    end
    // R5: all codes with and without override
    for (int i = 0; i < 8; i++) begin
      rcode = 3'(i); ovr = 1'b1; step(1);
      ovr = 1'b0; step(1);
    end
    // second window: mobile, 3.3 V
    por = 1'b1; fs_pin = 3'b011; mode_pin = 1'b0; vsel_pin = 1'b0;
    step(3);
    por = 1'b0;
    // R9: stop pins forwarded after release
    for (int i = 0; i < 8; i++) begin
      dual_pin = 2'(i); fs_pin = ~fs_pin; mode_pin = i[1];
      step(1);
    end
    // short window reopened mid-guard
    por = 1'b1; mode_pin = 1'b1; fs_pin = 3'b110; step(1);
    por = 1'b0; step(1);
    por = 1'b1; step(1);
    por = 1'b0; step(4);
    chk_en = 1'b0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule